// File: doc/BRIEF.md
# Test Access Port Instruction Register and Decoder

This block holds the instruction register of a boundary-scan test port and turns the instruction it holds into selects for the data registers. A 4-bit shift stage is clocked on the rising edge of TCK. It loads a fixed capture pattern and shifts with TDI entering at the most significant bit, so the least significant bit leaves first. A parallel update stage loads on the falling edge of TCK while the external TAP controller reports Update-IR. It holds the active instruction as one of four named states: `ST_EXTEST`, `ST_SAMPLE`, `ST_IDCODE` and `ST_BYPASS`.

The block also contains the 32-bit identification register and the 1-bit bypass register. It drives a TDO flip-flop on the falling edge of TCK. That flip-flop chooses between the instruction shift stage, the boundary register's serial output (an input to this block), the identification register and the bypass register. The TAP state machine and the boundary cells sit outside this block. They connect through capture, shift and update strobes and an active-low test-logic reset.

There are three kinds of state transition. An asynchronous reset places the update stage in `ST_IDCODE`. An update-IR strobe moves it to whichever state the decoded opcode names. With no update strobe the state holds.

Top module: `tap_instr_decoder`

## Requirements
- R1: While `rst_n` is low, the active instruction is `ST_IDCODE`. Only `sel_ident` is 1, `pad_test_mode` is 0, `tdo` is 0, and the shift stage holds 4'b0001. Shifting it out before any capture gives TDO bits 1,0,0,0.
- R2: A cycle with `ir_capture` high loads 4'b0001 into the shift stage. The following shift cycles give TDO bits 1,0,0,0.
- R3: A cycle with `ir_shift` high shifts the stage right, with TDI entering bit 3. During that cycle `tdo` shows bit 0 from the falling edge onward.
- R4: The active instruction changes only on a falling TCK edge with `ir_update` high. Shift and capture cycles leave the selects unchanged.
- R5: Opcodes 4'd7 and 4'd0 both give `ST_EXTEST`: `sel_boundary`=1 and `pad_test_mode`=1.
- R6: Opcode 4'd2 gives `ST_SAMPLE`: `sel_boundary`=1 and `pad_test_mode`=0.
- R7: Opcode 4'd1 gives `ST_IDCODE`: `sel_ident`=1.
- R8: Opcode 4'd14, and every opcode not named in R5 to R7, gives `ST_BYPASS`: `sel_bypass`=1.
- R9: A `dr_capture` cycle under `ST_IDCODE` loads 32'hFFFF_FFF5. This word has version 4'hF in bits 31:28, part 16'hFFFF in bits 27:12, maker code 11'h7FA in bits 11:1 and 1 in bit 0. The following `dr_shift` cycles give TDO bits 0 to 31 in order.
- R10: Under `ST_BYPASS`, `dr_capture` loads 0. Each `dr_shift` cycle delays TDI by one cycle before it reaches TDO.
- R11: In a non-IR-shift cycle with `sel_boundary` high, `tdo` takes `bsr_so` at the falling edge.
- R12: If reset is asserted in the same cycle as an `ir_update` strobe, reset wins and the active instruction becomes `ST_IDCODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous test-logic reset |
| tdi | input | 1 | Serial test data in |
| ir_capture | input | 1 | Controller is in Capture-IR |
| ir_shift | input | 1 | Controller is in Shift-IR |
| ir_update | input | 1 | Controller is in Update-IR |
| dr_capture | input | 1 | Controller is in Capture-DR |
| dr_shift | input | 1 | Controller is in Shift-DR |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| sel_boundary | output | 1 | Boundary register is on the scan path |
| sel_ident | output | 1 | Identification register is on the scan path |
| sel_bypass | output | 1 | Bypass register is on the scan path |
| pad_test_mode | output | 1 | Boundary register drives the pads |

## Verification
Two things can fall in the same cycle here: an asynchronous reset and an update-IR strobe that would otherwise load a new instruction. The bench shifts in an external-test opcode and then, in one cycle, raises `ir_update` and pulls `rst_n` low. It expects the identification selects at the falling edge and again afterwards. A behavioural reference model in the bench predicts every output at every falling edge. The bench compares all five outputs against the model once per clock.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;
    localparam int IR_W      = 4;
    localparam int ID_W      = 32;

    localparam logic [IR_W-1:0] OP_EXT_HI = 4'd7;
    localparam logic [IR_W-1:0] OP_EXT_LO = 4'd0;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'd2;
    localparam logic [IR_W-1:0] OP_IDENT  = 4'd1;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'd14;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    localparam logic [3:0]  ID_VERSION = 4'hF;
    localparam logic [15:0] ID_PART    = 16'hFFFF;
    localparam logic [10:0] ID_MAKER   = 11'h7FA;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    typedef enum logic [1:0] {
        ST_EXTEST,
        ST_SAMPLE,
        ST_IDCODE,
        ST_BYPASS
    } instr_e;
endpackage

// File: rtl/tap_ir_shift.sv
module tap_ir_shift
    import tap_ir_pkg::*;
#(
    parameter int WIDTH = IR_W
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tdi,
    input  logic             ir_capture,
    input  logic             ir_shift,
    output logic [WIDTH-1:0] sh_q
);
    localparam logic [WIDTH-1:0] CAP = IR_CAPTURE_PAT[WIDTH-1:0];

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)          sh_q <= CAP;
        else if (ir_capture) sh_q <= CAP;
        else if (ir_shift)   sh_q <= {tdi, sh_q[WIDTH-1:1]};
    end

    // R2
    ir_capture_pat_chk: assert property (@(posedge tck) disable iff (!rst_n)
        ir_capture |=> sh_q == CAP);

    // R3
    ir_shift_dir_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_shift && !ir_capture) |=> sh_q == {$past(tdi), $past(sh_q[WIDTH-1:1])});
endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
    import tap_ir_pkg::*;
#(
    parameter int WIDTH = IR_W
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             ir_update,
    input  logic [WIDTH-1:0] opcode,
    output logic             sel_boundary,
    output logic             sel_ident,
    output logic             sel_bypass,
    output logic             pad_test_mode
);
    instr_e state_q, state_d;

    // next state from the opcode held in the shift stage
    always_comb begin
        if (opcode == OP_EXT_HI || opcode == OP_EXT_LO) state_d = ST_EXTEST;
        else if (opcode == OP_SAMPLE)                   state_d = ST_SAMPLE;
        else if (opcode == OP_IDENT)                    state_d = ST_IDCODE;
        else                                            state_d = ST_BYPASS;
    end

    // state register: update stage on falling TCK
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)         state_q <= ST_IDCODE;
        else if (ir_update) state_q <= state_d;
    end

    // outputs
    always_comb begin
        sel_boundary  = 1'b0;
        sel_ident     = 1'b0;
        sel_bypass    = 1'b0;
        pad_test_mode = 1'b0;
        unique case (state_q)
            ST_EXTEST: begin sel_boundary = 1'b1; pad_test_mode = 1'b1; end
            ST_SAMPLE: sel_boundary = 1'b1;
            ST_IDCODE: sel_ident    = 1'b1;
            ST_BYPASS: sel_bypass   = 1'b1;
            default:   sel_bypass   = 1'b1;
        endcase
    end

    // R4
    instr_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
        !ir_update |=> $stable(state_q));

    // R4
    sel_onehot_chk: assert property (@(posedge tck) disable iff (!rst_n)
        $countones({sel_boundary, sel_ident, sel_bypass}) == 1);

    // R5
    pad_mode_bsr_chk: assert property (@(posedge tck) disable iff (!rst_n)
        pad_test_mode |-> sel_boundary);
endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
    import tap_ir_pkg::*;
#(
    parameter int               IDW     = ID_W,
    parameter logic [IDW-1:0]   ID_INIT = ID_WORD
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tdi,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic ir_shift,
    input  logic ir_lsb,
    input  logic bsr_so,
    input  logic sel_boundary,
    input  logic sel_ident,
    input  logic sel_bypass,
    output logic tdo
);
    logic [IDW-1:0] id_q;
    logic           byp_q;
    logic           tdo_d;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                     id_q <= '0;
        else if (sel_ident && dr_capture) id_q <= ID_INIT;
        else if (sel_ident && dr_shift)   id_q <= {tdi, id_q[IDW-1:1]};
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                        byp_q <= 1'b0;
        else if (sel_bypass && dr_capture) byp_q <= 1'b0;
        else if (sel_bypass && dr_shift)   byp_q <= tdi;
    end

    always_comb begin
        if (ir_shift)          tdo_d = ir_lsb;
        else if (sel_boundary) tdo_d = bsr_so;
        else if (sel_ident)    tdo_d = id_q[0];
        else                   tdo_d = byp_q;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= tdo_d;
    end

    // R10
    bypass_delay_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_bypass && dr_shift && !dr_capture) |=> byp_q == $past(tdi));

    // R9
    ident_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_ident && dr_capture) |=> id_q == ID_INIT);
endmodule

// File: rtl/tap_instr_decoder.sv
module tap_instr_decoder
    import tap_ir_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic tdi,
    input  logic ir_capture,
    input  logic ir_shift,
    input  logic ir_update,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic bsr_so,
    output logic tdo,
    output logic sel_boundary,
    output logic sel_ident,
    output logic sel_bypass,
    output logic pad_test_mode
);
    logic [IR_W-1:0] ir_sh;

    tap_ir_shift #(.WIDTH(IR_W)) u_shift (
        .tck(tck), .rst_n(rst_n), .tdi(tdi),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .sh_q(ir_sh)
    );

    tap_ir_decode #(.WIDTH(IR_W)) u_decode (
        .tck(tck), .rst_n(rst_n), .ir_update(ir_update), .opcode(ir_sh),
        .sel_boundary(sel_boundary), .sel_ident(sel_ident),
        .sel_bypass(sel_bypass), .pad_test_mode(pad_test_mode)
    );

    tap_dr_path #(.IDW(ID_W), .ID_INIT(ID_WORD)) u_drs (
        .tck(tck), .rst_n(rst_n), .tdi(tdi),
        .dr_capture(dr_capture), .dr_shift(dr_shift),
        .ir_shift(ir_shift), .ir_lsb(ir_sh[0]), .bsr_so(bsr_so),
        .sel_boundary(sel_boundary), .sel_ident(sel_ident),
        .sel_bypass(sel_bypass), .tdo(tdo)
    );
endmodule

// File: tb/tb_tap_instr_decoder.sv
module tb_tap_instr_decoder;
    localparam time HALF = 10ns;

    logic tck = 1'b0;
    logic rst_n = 1'b0, tdi = 1'b0, ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, bsr_so = 1'b0;
    logic tdo, sel_boundary, sel_ident, sel_bypass, pad_test_mode;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0]  m_ir  = 4'b0001;
    logic [3:0]  m_op  = 4'd1;
    logic [31:0] m_id  = '0;
    logic        m_byp = 1'b0;
    logic        m_tdo = 1'b0;
    localparam logic [31:0] ID_EXP = 32'hFFFF_FFF5;

    always #HALF tck = ~tck;

    tap_instr_decoder dut (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .ir_capture(ir_capture),
        .ir_shift(ir_shift), .ir_update(ir_update), .dr_capture(dr_capture),
        .dr_shift(dr_shift), .bsr_so(bsr_so), .tdo(tdo),
        .sel_boundary(sel_boundary), .sel_ident(sel_ident),
        .sel_bypass(sel_bypass), .pad_test_mode(pad_test_mode)
    );

    // 0 external test, 1 sample, 2 ident, 3 bypass
    function automatic int kind_of(input logic [3:0] op);
        if (op == 4'd7 || op == 4'd0) return 0;
        if (op == 4'd2) return 1;
        if (op == 4'd1) return 2;
        return 3;
    endfunction

    function automatic logic [3:0] exp_sels(input logic [3:0] op);
        case (kind_of(op))
            0: return 4'b1001;
            1: return 4'b1000;
            2: return 4'b0100;
            default: return 4'b0010;
        endcase
    endfunction

    task automatic step(input logic r, ci, si, ui, cd, sd, t, b, input string tag);
        logic [4:0] got, exp;
        int k;
        @(posedge tck); #2ns;
        rst_n = r; ir_capture = ci; ir_shift = si; ir_update = ui;
        dr_capture = cd; dr_shift = sd; tdi = t; bsr_so = b;
        @(negedge tck);
        k = kind_of(m_op);
        if (!r) begin
            m_ir = 4'b0001; m_op = 4'd1; m_id = '0; m_byp = 1'b0; m_tdo = 1'b0;
        end else begin
            if (si)          m_tdo = m_ir[0];
            else if (k <= 1) m_tdo = b;
            else if (k == 2) m_tdo = m_id[0];
            else             m_tdo = m_byp;
            if (ui) m_op = m_ir;
        end
        #3ns;
        got = {sel_boundary, sel_ident, sel_bypass, pad_test_mode, tdo};
        exp = {exp_sels(m_op)[3], exp_sels(m_op)[2], exp_sels(m_op)[1], exp_sels(m_op)[0], m_tdo};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {bsr,id,byp,mode,tdo} actual %b expected %b at %0t", tag, got, exp, $time);
        end
        // effects of the coming rising edge
        if (r) begin
            k = kind_of(m_op);
            if (ci)      m_ir = 4'b0001;
            else if (si) m_ir = {t, m_ir[3:1]};
            if (k == 2) begin
                if (cd)      m_id = ID_EXP;
                else if (sd) m_id = {t, m_id[31:1]};
            end
            if (k == 3) begin
                if (cd)      m_byp = 1'b0;
                else if (sd) m_byp = t;
            end
        end
    endtask

    task automatic idle(input string tag);
        step(1, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic load_ir(input logic [3:0] op, input logic upd, input string tag);
        step(1, 1, 0, 0, 0, 0, 0, 0, tag);
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, op[i], 0, tag);
        step(1, 0, 0, upd, 0, 0, 0, 0, tag);
        idle(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        idle("R1");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, 0, 0, "R1_shiftout");
        idle("R1");
        // R2 capture pattern, R3 shift
        step(1, 1, 0, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, i[0], 0, "R2");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, 1'b1, 0, "R3");
        // R4 no update: selects hold
        load_ir(4'd7, 1'b0, "R4");
        // R5 both external test codes, R11 boundary path
        load_ir(4'd7, 1'b1, "R5");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 1, 0, i[1], "R11");
        load_ir(4'd14, 1'b1, "R8");
        load_ir(4'd0, 1'b1, "R5");
        // R6 sample
        load_ir(4'd2, 1'b1, "R6");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 1, 0, ~i[0], "R11");
        // R7 and R9 identification
        load_ir(4'd1, 1'b1, "R7");
        step(1, 0, 0, 0, 1, 0, 0, 0, "R9");
        for (int i = 0; i < 33; i++) step(1, 0, 0, 0, 0, 1, 0, 0, "R9");
        // R8 unassigned codes, R10 bypass
        load_ir(4'd5, 1'b1, "R8");
        load_ir(4'd15, 1'b1, "R8");
        load_ir(4'd3, 1'b1, "R8");
        step(1, 0, 0, 0, 1, 0, 0, 0, "R10");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 1, i[0] ^ i[2], 0, "R10");
        load_ir(4'd14, 1'b1, "R8");
        // R12 reset in the same cycle as update
        load_ir(4'd7, 1'b0, "R12");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R12");
        idle("R12");
        idle("R12");
        finish_run();
    end
endmodule